// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Adder/Subtractor

This block computes a small add or subtract entirely in dual-rail form. Each logical bit travels as a pair of wires: a true wire and a false wire. A phase input alternates between a precharge phase and an evaluation phase. During precharge every pair is held at 00. During evaluation exactly one wire of each pair rises, and it rises once. The arithmetic network is built only from monotonic AND and OR compound gates. Logical inversion uses no inverter cell; it is done by swapping the two wires of a pair.

Single-rail operands enter through an encoder. The encoder releases them into the network only while the phase input is high. The network output pairs are sampled every clock into a snapshot register, which is exposed at the ports. When an evaluation phase ends, the true wires of the snapshot are decoded into single-rail result registers, and a valid flag pulses for one cycle. A rail monitor raises an error flag on any illegal pair. Operands must be held steady while the phase input is high.

Top module: `drpl_adder_top`

## Requirements
- R1: After any clock edge at which `phaseEval` is sampled low, every bit of `dualT` and `dualF` reads 0.
- R2: After any clock edge at which `phaseEval` is sampled high, each bit position holds exactly one high wire: `dualT ^ dualF` is all ones and `dualT & dualF` is zero.
- R3: During evaluation the true wires carry the logical value: `dualT` equals `{carry, sum}` of the selected operation, and `dualF` is its bitwise complement.
- R4: With `subIn` = 0, the captured `{carryOut, resOut}` equals `aIn + bIn` as a WIDTH+1 bit sum.
- R5: With `subIn` = 1, the captured `{carryOut, resOut}` equals `aIn + ~bIn + 1`, truncated to WIDTH+1 bits. The top bit is 1 when there is no borrow.
- R6: `resOut` and `carryOut` change only at the first clock edge at which `phaseEval` is sampled low after being sampled high. At that edge they take the true wires of the snapshot from the last evaluation cycle. They hold at every other edge, including while the operands change during precharge.
- R7: `validOut` is high for exactly the one cycle that follows a capture edge, and low otherwise.
- R8: `errOut` pulses when the snapshot holds a pair reading 11, or when a pair reads 00 at a capture edge. Under legal phase operation it stays low.
- R9: While `rstN` is low, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseEval | input | 1 | 1 = evaluation phase, 0 = precharge phase |
| aIn | input | WIDTH | First operand, single rail |
| bIn | input | WIDTH | Second operand, single rail |
| subIn | input | 1 | 1 = subtract, 0 = add |
| resOut | output | WIDTH | Captured result, single rail |
| carryOut | output | 1 | Captured carry out (no-borrow flag when subtracting) |
| validOut | output | 1 | One-cycle pulse after each capture |
| dualT | output | WIDTH+1 | Snapshot of the true wires of the network outputs |
| dualF | output | WIDTH+1 | Snapshot of the false wires of the network outputs |
| errOut | output | 1 | Rail-code violation pulse |

## Verification
A swapped pair of wires in a compound gate, or a gate that is not gated by the phase input, shows up in the exposed snapshot one clock after the faulty phase. It appears either as a wrong true-wire value, a 11 or 00 pair during evaluation, or a nonzero wire during precharge. Capture-timing faults appear at the ports one cycle after the phase input falls, as a missing or misplaced valid pulse or as a result that moves outside a capture edge. Every operand pair in both modes goes through phases of random length, so a carry-chain fault is exposed in the first operation that uses that carry path.

// File: rtl/drpl_pkg.sv
package drpl_pkg;

  // One logical bit carried on two wires.
  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic encEnable;
    logic capture;
  } strobes_t;

  // Compound AND: AND on true wires, OR on false wires.
  function automatic rail_t dAnd(rail_t x, rail_t y);
    rail_t r;
    r.t = x.t & y.t;
    r.f = x.f | y.f;
    return r;
  endfunction

  // Compound OR: OR on true wires, AND on false wires.
  function automatic rail_t dOr(rail_t x, rail_t y);
    rail_t r;
    r.t = x.t | y.t;
    r.f = x.f & y.f;
    return r;
  endfunction

  // Inversion by exchanging wires, no gate involved.
  function automatic rail_t dNot(rail_t x);
    rail_t r;
    r.t = x.f;
    r.f = x.t;
    return r;
  endfunction

  function automatic rail_t dXor(rail_t x, rail_t y);
    return dOr(dAnd(x, dNot(y)), dAnd(dNot(x), y));
  endfunction

endpackage

// File: rtl/drpl_encoder.sv
module drpl_encoder
  import drpl_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic                 en,
  input  logic [WIDTH-1:0]     val,
  output rail_t [WIDTH-1:0]    rails
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign rails[i].t = en & val[i];
    assign rails[i].f = en & ~val[i];
  end

endmodule

// File: rtl/drpl_network.sv
module drpl_network
  import drpl_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  rail_t [WIDTH-1:0] opA,
  input  rail_t [WIDTH-1:0] opB,
  input  rail_t             subSel,
  output rail_t [WIDTH:0]   result
);

  rail_t [WIDTH:0]   carry;
  rail_t [WIDTH-1:0] bEff;
  rail_t [WIDTH-1:0] prop;

  assign carry[0] = subSel;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign bEff[i]      = dXor(opB[i], subSel);
    assign prop[i]      = dXor(opA[i], bEff[i]);
    assign result[i]    = dXor(prop[i], carry[i]);
    assign carry[i+1]   = dOr(dAnd(opA[i], bEff[i]), dAnd(prop[i], carry[i]));
  end

  assign result[WIDTH] = carry[WIDTH];

endmodule

// File: rtl/drpl_control.sv
module drpl_control
  import drpl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     phaseEval,
  output strobes_t strobes,
  output logic     validOut
);

  logic phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= 1'b0;
      validOut <= 1'b0;
    end else begin
      phaseQ   <= phaseEval;
      validOut <= strobes.capture;
    end
  end

  always_comb begin
    strobes.encEnable = phaseEval;
    strobes.capture   = phaseQ & ~phaseEval;
  end

endmodule

// File: rtl/drpl_datapath.sv
module drpl_datapath
  import drpl_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             subIn,
  output logic [WIDTH-1:0] resOut,
  output logic             carryOut,
  output logic [WIDTH:0]   dualT,
  output logic [WIDTH:0]   dualF,
  output logic             errOut
);

  localparam int OUTW = WIDTH + 1;

  rail_t [WIDTH-1:0] aRails;
  rail_t [WIDTH-1:0] bRails;
  rail_t [0:0]       subRails;
  rail_t [WIDTH:0]   netOut;
  rail_t [WIDTH:0]   railQ;
  logic  [OUTW-1:0]  bothHigh;
  logic  [OUTW-1:0]  bothLow;

  drpl_encoder #(.WIDTH(WIDTH)) encA_i (
    .en(strobes.encEnable), .val(aIn), .rails(aRails)
  );

  drpl_encoder #(.WIDTH(WIDTH)) encB_i (
    .en(strobes.encEnable), .val(bIn), .rails(bRails)
  );

  drpl_encoder #(.WIDTH(1)) encS_i (
    .en(strobes.encEnable), .val(subIn), .rails(subRails)
  );

  drpl_network #(.WIDTH(WIDTH)) net_i (
    .opA(aRails), .opB(bRails), .subSel(subRails[0]), .result(netOut)
  );

  // Snapshot of the network outputs, taken every cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) railQ <= '0;
    else       railQ <= netOut;
  end

  for (genvar i = 0; i < OUTW; i++) begin : g_split
    assign dualT[i]    = railQ[i].t;
    assign dualF[i]    = railQ[i].f;
    assign bothHigh[i] = railQ[i].t & railQ[i].f;
    assign bothLow[i]  = ~railQ[i].t & ~railQ[i].f;
  end

  // Decoder and rail monitor.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resOut   <= '0;
      carryOut <= 1'b0;
      errOut   <= 1'b0;
    end else begin
      if (strobes.capture) begin
        resOut   <= dualT[WIDTH-1:0];
        carryOut <= dualT[WIDTH];
      end
      errOut <= (|bothHigh) | (strobes.capture & (|bothLow));
    end
  end

endmodule

// File: rtl/drpl_adder_top.sv
module drpl_adder_top
  import drpl_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseEval,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             subIn,
  output logic [WIDTH-1:0] resOut,
  output logic             carryOut,
  output logic             validOut,
  output logic [WIDTH:0]   dualT,
  output logic [WIDTH:0]   dualF,
  output logic             errOut
);

  strobes_t strobes;

  drpl_control ctrl_i (
    .clk(clk), .rstN(rstN), .phaseEval(phaseEval),
    .strobes(strobes), .validOut(validOut)
  );

  drpl_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aIn(aIn), .bIn(bIn), .subIn(subIn),
    .resOut(resOut), .carryOut(carryOut),
    .dualT(dualT), .dualF(dualF), .errOut(errOut)
  );

endmodule

// File: rtl/drpl_adder_chk.sv
module drpl_adder_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             phaseEval,
  input logic [WIDTH-1:0] resOut,
  input logic             carryOut,
  input logic             validOut,
  input logic [WIDTH:0]   dualT,
  input logic [WIDTH:0]   dualF,
  input logic             errOut
);

  // R1
  precharge_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !phaseEval |=> (dualT == '0 && dualF == '0));

  // R2
  eval_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseEval |=> ((dualT ^ dualF) == '1 && (dualT & dualF) == '0));

  // R6
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> ({carryOut, resOut} == $past(dualT)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> $stable({carryOut, resOut}));

  // R7
  valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (!$past(phaseEval) && $past(phaseEval, 2)));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut);

  // R8
  no_rail_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    !errOut);

endmodule

bind drpl_adder_top drpl_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .phaseEval(phaseEval),
  .resOut(resOut), .carryOut(carryOut), .validOut(validOut),
  .dualT(dualT), .dualF(dualF), .errOut(errOut)
);

// File: tb/drpl_adder_top_tb_top.sv
module drpl_adder_top_tb_top;

  localparam int WIDTH = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             phaseEval = 1'b0;
  logic [WIDTH-1:0] aIn = '0;
  logic [WIDTH-1:0] bIn = '0;
  logic             subIn = 1'b0;
  logic [WIDTH-1:0] resOut;
  logic             carryOut;
  logic             validOut;
  logic [WIDTH:0]   dualT;
  logic [WIDTH:0]   dualF;
  logic             errOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  drpl_adder_top #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rstN(rstN), .phaseEval(phaseEval),
    .aIn(aIn), .bIn(bIn), .subIn(subIn),
    .resOut(resOut), .carryOut(carryOut), .validOut(validOut),
    .dualT(dualT), .dualF(dualF), .errOut(errOut)
  );

  function automatic logic [WIDTH:0] model(logic [WIDTH-1:0] a,
                                           logic [WIDTH-1:0] b, logic s);
    if (s) return {1'b0, a} + {1'b0, ~b} + (WIDTH+1)'(1);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                      input logic s, input int preLen, input int evalLen);
    logic [WIDTH:0] exp;
    logic [WIDTH:0] prev;
    exp  = model(a, b, s);
    prev = {carryOut, resOut};
    // junk operands during precharge must not matter
    aIn = ~a; bIn = b ^ 4'h5; subIn = ~s;
    phaseEval = 1'b0;
    @(negedge clk);
    check(validOut == 1'b0, "R7 valid low in precharge", 32'(validOut), 0);
    check({carryOut, resOut} == prev, "R6 hold in precharge",
          32'({carryOut, resOut}), 32'(prev));
    aIn = a; bIn = b; subIn = s;
    repeat (preLen) @(negedge clk);
    check(dualT == '0 && dualF == '0, "R1 rails zero after precharge",
          32'({dualT, dualF}), 0);
    phaseEval = 1'b1;
    repeat (evalLen) @(negedge clk);
    check((dualT ^ dualF) == '1 && (dualT & dualF) == '0, "R2 one wire per pair",
          32'({dualT, dualF}), 32'({exp, ~exp}));
    check(dualT == exp && dualF == ~exp, "R3 true wires carry value",
          32'({dualT, dualF}), 32'({exp, ~exp}));
    check({carryOut, resOut} == prev, "R6 hold during evaluation",
          32'({carryOut, resOut}), 32'(prev));
    phaseEval = 1'b0;
    @(negedge clk);
    check(validOut == 1'b1, "R7 valid after capture", 32'(validOut), 1);
    check({carryOut, resOut} == exp, s ? "R5 subtract result" : "R4 add result",
          32'({carryOut, resOut}), 32'(exp));
    check(errOut == 1'b0, "R8 no rail error", 32'(errOut), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(resOut == '0 && carryOut == 1'b0, "R9 result zero in reset",
          32'({carryOut, resOut}), 0);
    check(validOut == 1'b0 && errOut == 1'b0, "R9 flags zero in reset",
          32'({validOut, errOut}), 0);
    check(dualT == '0 && dualF == '0, "R9 rails zero in reset",
          32'({dualT, dualF}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    doOp(4'hF, 4'h1, 1'b0, 0, 1);  // R4 wrap with carry
    doOp(4'hF, 4'hF, 1'b0, 2, 1);  // R4 max sum
    doOp(4'h7, 4'h7, 1'b1, 1, 4);  // R5 equal operands, no borrow
    doOp(4'h0, 4'h1, 1'b1, 0, 1);  // R5 borrow
    doOp(4'h0, 4'h0, 1'b0, 3, 2);  // R4 zero

    // every operand pair in both modes, random phase lengths
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          doOp(4'(a), 4'(b), 1'(s), int'($urandom % 3), 1 + int'($urandom % 3));
        end
      end
    end

    // final result holds through a long precharge (R6, R7)
    phaseEval = 1'b0;
    @(negedge clk);
    begin
      logic [WIDTH:0] last;
      last = {carryOut, resOut};
      repeat (5) @(negedge clk);
      check({carryOut, resOut} == last && validOut == 1'b0, "R6 hold long precharge",
            32'({carryOut, resOut}), 32'(last));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule